// File: doc/BRIEF.md
# Accumulator ALU with Flag-Tested Modify Unit

This block is the arithmetic core of a 16-bit signal processor. It holds a 32-bit accumulator. A 16-bit operand always lands in the accumulator's upper half before it is combined, so the lower half acts as extra precision that only shifts and negation ever bring into play. A 3-bit code picks one of six two-operand operations: add, subtract, compare, AND, OR and XOR. Each legal operation refreshes a zero flag and a sign flag. The two flags sit at fixed bits of a 16-bit status word.

A condition evaluator reads the stored flags and reports, without a clock, whether a chosen test passes. The surrounding sequencer uses this result for conditional branches. Inside the block the same result gates a group of single-operand modify operations on the accumulator: arithmetic shift right, shift left, negate and absolute value. Every result is computed in one cycle and registered on the rising clock edge. Operand fetch and program flow belong to the surrounding logic.

Top module: `accAluTop`

## Requirements
- R1: While rstN is low, the accumulator and every status bit are cleared to zero on the clock edge.
- R2: With opValid high, code 4 adds and code 1 subtracts the operand shifted left by 16 (operand in bits 31:16, zeros below) to or from the accumulator. The result is written on the next rising edge.
- R3: Codes 5, 6 and 7 perform AND, OR and XOR between the accumulator and the aligned operand. As a result, AND clears the lower half, while OR and XOR leave it as it was.
- R4: Code 3 (compare) sets the flags from the accumulator minus the aligned operand and leaves the accumulator unchanged.
- R5: The status word carries Z (result equal to zero) at bit 13 and N (result bit 31) at bit 15. All other status bits read zero. Every legal ALU code updates both flags.
- R6: ALU codes 0 and 2 are illegal and leave the accumulator and status unchanged.
- R7: condPass is combinational from the stored flags. The tested flag is 1 for condition code 0, Z for code 5, N for code 7 and 0 for any other code. condSense=1 passes when the tested flag is 1, and condSense=0 passes when it is 0.
- R8: With modValid high and condPass true, modify code 2 shifts the accumulator right arithmetically by one, code 3 shifts it left by one and code 6 negates it. Each of these updates both Z and N.
- R9: Modify code 7 replaces the accumulator with its absolute value and updates N only; Z keeps its previous value. The value 0x80000000 stays 0x80000000.
- R10: A modify request whose condition fails, or whose code is 0, 1, 4 or 5, leaves the accumulator and status unchanged.
- R11: When opValid and modValid are both high, the ALU request is carried out and the modify request is ignored.
- R12: Results are registered. The accumulator and status outputs do not change before the rising edge that captures a request, and they show the result right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| opValid | input | 1 | Two-operand ALU request this cycle |
| opCode | input | 3 | ALU operation code |
| operand | input | 16 | Operand, placed in accumulator bits 31:16 |
| modValid | input | 1 | Conditional modify request this cycle |
| modCode | input | 3 | Modify operation code |
| condCode | input | 4 | Selects the flag that the condition tests |
| condSense | input | 1 | 1 = pass when the flag is set, 0 = pass when it is clear |
| condPass | output | 1 | Result of the condition test on the current flags |
| acc | output | 32 | Accumulator |
| status | output | 16 | Status word: Z at bit 13, N at bit 15 |

## Verification
A wrong accumulator value shows on the acc port on the edge after the request that produced it. Every later arithmetic result then carries the error forward, so a single bad step spoils all the expected values that follow in the vector walk. A flag that is stored wrongly shows at once in status bits 13 and 15 and on condPass in the same cycle. It also sends a following conditional modify the wrong way, which in turn shows on acc one edge later. A write strobe that fires when it should not (compare, an illegal code, a failed condition, the Z flag during absolute value) is caught on the very next edge by comparison against the value held before.

// File: rtl/accAluPkg.sv
package accAluPkg;

  // two-operand ALU codes
  localparam logic [2:0] ALU_SUB = 3'd1;
  localparam logic [2:0] ALU_CMP = 3'd3;
  localparam logic [2:0] ALU_ADD = 3'd4;
  localparam logic [2:0] ALU_AND = 3'd5;
  localparam logic [2:0] ALU_OR  = 3'd6;
  localparam logic [2:0] ALU_XOR = 3'd7;

  // conditional modify codes
  localparam logic [2:0] MOD_ASR = 3'd2;
  localparam logic [2:0] MOD_SHL = 3'd3;
  localparam logic [2:0] MOD_NEG = 3'd6;
  localparam logic [2:0] MOD_ABS = 3'd7;

  // condition selector codes
  localparam logic [3:0] COND_ALWAYS = 4'd0;
  localparam logic [3:0] COND_ZERO   = 4'd5;
  localparam logic [3:0] COND_NEG    = 4'd7;

  // status word layout
  localparam int unsigned Z_BIT = 13;
  localparam int unsigned N_BIT = 15;

  typedef struct packed {
    logic       accWe;
    logic       zWe;
    logic       nWe;
    logic       selMod;
    logic [2:0] aluOp;
    logic [2:0] modOp;
  } ctrlStrobe_t;

endpackage

// File: rtl/accAluCond.sv
module accAluCond
  import accAluPkg::*;
(
  input  logic [3:0] condCode,
  input  logic       condSense,
  input  logic       zFlag,
  input  logic       nFlag,
  output logic       condPass
);

  logic testedFlag;

  always_comb begin
    unique case (condCode)
      COND_ALWAYS: testedFlag = 1'b1;
      COND_ZERO:   testedFlag = zFlag;
      COND_NEG:    testedFlag = nFlag;
      default:     testedFlag = 1'b0;
    endcase
  end

  // sense 1 looks for a set flag, sense 0 for a clear one
  assign condPass = condSense ? testedFlag : ~testedFlag;

endmodule

// File: rtl/accAluCtrl.sv
module accAluCtrl
  import accAluPkg::*;
(
  input  logic        opValid,
  input  logic [2:0]  opCode,
  input  logic        modValid,
  input  logic [2:0]  modCode,
  input  logic        condPass,
  output ctrlStrobe_t strobe
);

  logic aluLegal;
  logic modLegal;
  logic doAlu;
  logic doMod;

  always_comb begin
    unique case (opCode)
      ALU_SUB, ALU_CMP, ALU_ADD, ALU_AND, ALU_OR, ALU_XOR: aluLegal = 1'b1;
      default:                                              aluLegal = 1'b0;
    endcase
    unique case (modCode)
      MOD_ASR, MOD_SHL, MOD_NEG, MOD_ABS: modLegal = 1'b1;
      default:                            modLegal = 1'b0;
    endcase
  end

  // an ALU request always outranks a modify request
  assign doAlu = opValid & aluLegal;
  assign doMod = ~opValid & modValid & modLegal & condPass;

  always_comb begin
    strobe        = '0;
    strobe.aluOp  = opCode;
    strobe.modOp  = modCode;
    strobe.selMod = doMod;
    strobe.accWe  = (doAlu & (opCode != ALU_CMP)) | doMod;
    strobe.zWe    = doAlu | (doMod & (modCode != MOD_ABS));
    strobe.nWe    = doAlu | doMod;
  end

endmodule

// File: rtl/accAluPath.sv
module accAluPath
  import accAluPkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DATA_W-1:0]     operand,
  input  ctrlStrobe_t           strobe,
  output logic [2*DATA_W-1:0]   acc,
  output logic                  zFlag,
  output logic                  nFlag
);

  localparam int unsigned ACC_W = 2 * DATA_W;

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] aligned;
  logic [ACC_W-1:0] aluRes;
  logic [ACC_W-1:0] modRes;
  logic [ACC_W-1:0] result;
  logic             zQ;
  logic             nQ;

  assign aligned = {operand, {DATA_W{1'b0}}};

  always_comb begin
    unique case (strobe.aluOp)
      ALU_SUB, ALU_CMP: aluRes = accQ - aligned;
      ALU_ADD:          aluRes = accQ + aligned;
      ALU_AND:          aluRes = accQ & aligned;
      ALU_OR:           aluRes = accQ | aligned;
      ALU_XOR:          aluRes = accQ ^ aligned;
      default:          aluRes = accQ;
    endcase
  end

  always_comb begin
    unique case (strobe.modOp)
      MOD_ASR: modRes = {accQ[ACC_W-1], accQ[ACC_W-1:1]};
      MOD_SHL: modRes = {accQ[ACC_W-2:0], 1'b0};
      MOD_NEG: modRes = {ACC_W{1'b0}} - accQ;
      MOD_ABS: modRes = accQ[ACC_W-1] ? ({ACC_W{1'b0}} - accQ) : accQ;
      default: modRes = accQ;
    endcase
  end

  assign result = strobe.selMod ? modRes : aluRes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
      zQ   <= 1'b0;
      nQ   <= 1'b0;
    end else begin
      if (strobe.accWe) accQ <= result;
      if (strobe.zWe)   zQ   <= (result == '0);
      if (strobe.nWe)   nQ   <= result[ACC_W-1];
    end
  end

  assign acc   = accQ;
  assign zFlag = zQ;
  assign nFlag = nQ;

endmodule

// File: rtl/accAluTop.sv
module accAluTop
  import accAluPkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STAT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [2:0]          opCode,
  input  logic [DATA_W-1:0]   operand,
  input  logic                modValid,
  input  logic [2:0]          modCode,
  input  logic [3:0]          condCode,
  input  logic                condSense,
  output logic                condPass,
  output logic [2*DATA_W-1:0] acc,
  output logic [STAT_W-1:0]   status
);

  ctrlStrobe_t strobe;
  logic        zFlag;
  logic        nFlag;

  accAluCond u_cond (
    .condCode (condCode),
    .condSense(condSense),
    .zFlag    (zFlag),
    .nFlag    (nFlag),
    .condPass (condPass)
  );

  accAluCtrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .modValid(modValid),
    .modCode (modCode),
    .condPass(condPass),
    .strobe  (strobe)
  );

  accAluPath #(.DATA_W(DATA_W)) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .operand(operand),
    .strobe (strobe),
    .acc    (acc),
    .zFlag  (zFlag),
    .nFlag  (nFlag)
  );

  always_comb begin
    status        = '0;
    status[Z_BIT] = zFlag;
    status[N_BIT] = nFlag;
  end

endmodule

// File: rtl/accAluChk.sv
module accAluChk
  import accAluPkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STAT_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                opValid,
  input logic [2:0]          opCode,
  input logic [DATA_W-1:0]   operand,
  input logic                modValid,
  input logic [2:0]          modCode,
  input logic                condPass,
  input logic [2*DATA_W-1:0] acc,
  input logic [STAT_W-1:0]   status
);

  localparam logic [STAT_W-1:0] FLAG_MASK = (STAT_W'(1) << Z_BIT) | (STAT_W'(1) << N_BIT);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (acc == '0 && status == '0));

  p_add_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == ALU_ADD) |=>
      acc == $past(acc) + {$past(operand), {DATA_W{1'b0}}});

  p_cmp_keeps_acc_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == ALU_CMP) |=> acc == $past(acc));

  p_spare_bits_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (status & ~FLAG_MASK) == '0);

  p_illegal_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 3'd0 || opCode == 3'd2)) |=>
      (acc == $past(acc) && status == $past(status)));

  p_abs_keeps_z_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && modValid && condPass && modCode == MOD_ABS) |=>
      status[Z_BIT] == $past(status[Z_BIT]));

  p_fail_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && modValid && !condPass) |=>
      (acc == $past(acc) && status == $past(status)));

  p_alu_first_r11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && modValid && opCode == ALU_CMP) |=> acc == $past(acc));

endmodule

bind accAluTop accAluChk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .opCode  (opCode),
  .operand (operand),
  .modValid(modValid),
  .modCode (modCode),
  .condPass(condPass),
  .acc     (acc),
  .status  (status)
);

// File: tb/accAluTop_tb.sv
`timescale 1ns/100ps
module accAluTop_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [15:0] operand = '0;
  logic        modValid = 1'b0;
  logic [2:0]  modCode = '0;
  logic [3:0]  condCode = '0;
  logic        condSense = 1'b0;
  logic        condPass;
  logic [31:0] acc;
  logic [15:0] status;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  accAluTop u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .operand(operand), .modValid(modValid), .modCode(modCode),
    .condCode(condCode), .condSense(condSense), .condPass(condPass),
    .acc(acc), .status(status)
  );

  // vector: kind[59:58] (0 alu, 1 modify), code[57:55], cond[54:51],
  // sense[50], operand[49:34], expected acc[33:2], expected Z[1], N[0]
  localparam int NVEC = 21;
  localparam logic [59:0] VEC [NVEC] = '{
    {2'd0, 3'd4, 4'd0, 1'b0, 16'h1234, 32'h12340000, 1'b0, 1'b0},
    {2'd0, 3'd4, 4'd0, 1'b0, 16'h7000, 32'h82340000, 1'b0, 1'b1},
    {2'd0, 3'd1, 4'd0, 1'b0, 16'h8234, 32'h00000000, 1'b1, 1'b0},
    {2'd0, 3'd4, 4'd0, 1'b0, 16'hFFFF, 32'hFFFF0000, 1'b0, 1'b1},
    {2'd1, 3'd2, 4'd0, 1'b1, 16'h0000, 32'hFFFF8000, 1'b0, 1'b1},
    {2'd0, 3'd7, 4'd0, 1'b0, 16'hFFFF, 32'h00008000, 1'b0, 1'b0},
    {2'd0, 3'd6, 4'd0, 1'b0, 16'h1200, 32'h12008000, 1'b0, 1'b0},
    {2'd0, 3'd5, 4'd0, 1'b0, 16'h0F0F, 32'h02000000, 1'b0, 1'b0},
    {2'd0, 3'd3, 4'd0, 1'b0, 16'h0200, 32'h02000000, 1'b1, 1'b0},
    {2'd1, 3'd6, 4'd5, 1'b1, 16'h0000, 32'hFE000000, 1'b0, 1'b1},
    {2'd1, 3'd7, 4'd7, 1'b1, 16'h0000, 32'h02000000, 1'b0, 1'b0},
    {2'd1, 3'd3, 4'd7, 1'b1, 16'h0000, 32'h02000000, 1'b0, 1'b0},
    {2'd1, 3'd3, 4'd7, 1'b0, 16'h0000, 32'h04000000, 1'b0, 1'b0},
    {2'd0, 3'd2, 4'd0, 1'b0, 16'h5555, 32'h04000000, 1'b0, 1'b0},
    {2'd1, 3'd1, 4'd0, 1'b1, 16'h0000, 32'h04000000, 1'b0, 1'b0},
    {2'd1, 3'd6, 4'd3, 1'b1, 16'h0000, 32'h04000000, 1'b0, 1'b0},
    {2'd1, 3'd6, 4'd3, 1'b0, 16'h0000, 32'hFC000000, 1'b0, 1'b1},
    {2'd0, 3'd3, 4'd0, 1'b0, 16'hFC00, 32'hFC000000, 1'b1, 1'b0},
    {2'd1, 3'd7, 4'd5, 1'b1, 16'h0000, 32'h04000000, 1'b1, 1'b0},
    {2'd0, 3'd1, 4'd0, 1'b0, 16'h0400, 32'h00000000, 1'b1, 1'b0},
    {2'd1, 3'd3, 4'd0, 1'b1, 16'h0000, 32'h00000000, 1'b1, 1'b0}
  };

  function automatic logic [15:0] statOf(input logic z, input logic n);
    statOf = '0;
    statOf[13] = z;
    statOf[15] = n;
  endfunction

  function automatic string tagOf(input logic [1:0] kind, input logic [2:0] code,
                                  input logic [3:0] cnd, input logic sense,
                                  input logic [15:0] stat);
    logic fl;
    if (kind == 2'd0) begin
      case (code)
        3'd1, 3'd4: tagOf = "R2";
        3'd3:       tagOf = "R4";
        3'd5, 3'd6, 3'd7: tagOf = "R3";
        default:    tagOf = "R6";
      endcase
    end else begin
      fl = (cnd == 4'd0) ? 1'b1 : (cnd == 4'd5) ? stat[13] : (cnd == 4'd7) ? stat[15] : 1'b0;
      if ((sense ? fl : ~fl) == 1'b0) tagOf = "R10";
      else if (code == 3'd7) tagOf = "R9";
      else if (code == 3'd2 || code == 3'd3 || code == 3'd6) tagOf = "R8";
      else tagOf = "R10";
    end
  endfunction

  task automatic checkState(input string tag, input logic [31:0] expAcc,
                            input logic [15:0] expStat);
    checks++;
    if (acc !== expAcc || status !== expStat) begin
      failures++;
      $display("FAIL %s acc=%h status=%h expected acc=%h status=%h",
               tag, acc, status, expAcc, expStat);
    end
  endtask

  task automatic checkBit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample at the following negedge
  task automatic issue(input logic [1:0] kind, input logic [2:0] code,
                       input logic [3:0] cnd, input logic sense, input logic [15:0] opnd);
    opValid   = (kind == 2'd0);
    modValid  = (kind == 2'd1);
    opCode    = code;
    modCode   = code;
    condCode  = cnd;
    condSense = sense;
    operand   = opnd;
    @(posedge clk);
    @(negedge clk);
    opValid  = 1'b0;
    modValid = 1'b0;
  endtask

  task automatic sweepCond(input string tag);
    logic fl;
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 2; s++) begin
        condCode  = 4'(c);
        condSense = s[0];
        #0.5;
        fl = (c == 0) ? 1'b1 : (c == 5) ? status[13] : (c == 7) ? status[15] : 1'b0;
        checkBit(tag, condPass, s[0] ? fl : ~fl);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkState("R1 reset", 32'h0, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    sweepCond("R7 cond after reset");

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = tagOf(VEC[i][59:58], VEC[i][57:55], VEC[i][54:51], VEC[i][50], status);
      issue(VEC[i][59:58], VEC[i][57:55], VEC[i][54:51], VEC[i][50], VEC[i][49:34]);
      checkState(tag, VEC[i][33:2], statOf(VEC[i][1], VEC[i][0]));
      if (i == 8 || i == 9) sweepCond("R7 cond sweep");
    end

    // R11 and R12: both requests together; nothing moves before the edge
    opValid = 1'b1; opCode = 3'd4; operand = 16'h0001;
    modValid = 1'b1; modCode = 3'd6; condCode = 4'd0; condSense = 1'b1;
    #1;
    checkState("R12 before edge", 32'h0, statOf(1'b1, 1'b0));
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0; modValid = 1'b0;
    checkState("R11 alu wins", 32'h00010000, statOf(1'b0, 1'b0));

    // R9 corner: most negative value stays put, Z untouched
    issue(2'd0, 3'd4, 4'd0, 1'b0, 16'h7FFF);
    checkState("R2 to min", 32'h80000000, statOf(1'b0, 1'b1));
    issue(2'd1, 3'd7, 4'd0, 1'b1, 16'h0000);
    checkState("R9 abs min", 32'h80000000, statOf(1'b0, 1'b1));
    sweepCond("R7 cond negative");

    // R6 code 0 and R5 spare bits
    issue(2'd0, 3'd0, 4'd0, 1'b0, 16'hFFFF);
    checkState("R6 code0", 32'h80000000, statOf(1'b0, 1'b1));
    checkBit("R5 spare bits", |(status & 16'h5FFF), 1'b0);

    // R8 shift left out of the sign bit to zero
    issue(2'd1, 3'd3, 4'd7, 1'b1, 16'h0000);
    checkState("R8 shl to zero", 32'h0, statOf(1'b1, 1'b0));

    // R1 reset in mid-run
    issue(2'd0, 3'd6, 4'd0, 1'b0, 16'hABCD);
    checkState("R3 or", 32'hABCD0000, statOf(1'b0, 1'b1));
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkState("R1 reset mid-run", 32'h0, 16'h0);
    rstN = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule